// File: doc/BRIEF.md
# PHY Management Bus Controller

This block lets a host talk to an external Ethernet PHY over the two-wire management bus, which has a clock line and a bidirectional data line. The host sees a small word-indexed register set. It writes the target PHY and register numbers into an address register. It then starts a transaction in one of two ways. Setting bit 0 of the command register starts a read. Writing the write-data register starts a write. The controller shifts out a complete management frame, most significant bit first. On a read it lets go of the data line from the turnaround onward and collects the 16 bits the PHY returns.

The management clock is the system clock divided by a ratio picked from a fixed table. The host chooses the ratio so that the management clock stays under 2.5 MHz at its system clock rate. The host polls a busy flag until the transaction ends. For a read, it then fetches the result and clears the command bit. A hold bit in the configuration register keeps the whole engine idle.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset every register reads 0, the management clock is low and the data output enable is low.
- R2: Register word offsets are 0 config, 1 command, 2 address, 3 write data, 4 read data, 5 indicator; 6 and 7 read 0. Config holds the hold bit at bit 15 and the divider select at bits 4:2. The command bit is bit 0. Address holds the register number in bits 4:0 and the PHY number in bits 12:8. Write data uses bits 15:0. All other bits read 0.
- R3: A write frame is 32 ones, start 01, opcode 01, PHY number, register number, turnaround 10, then the 16 data bits. Every field goes out MSB first, with the output enable high for all 64 bits.
- R4: A read frame sends opcode 10. The output enable drops at frame bit 46 (the first turnaround bit) and stays low to the end. The 16 bits sampled at frame bits 48..63 land, MSB first, in read-data bits 15:0 when the frame ends.
- R5: Indicator bit 0 reads 1 from the cycle after the start write until the frame ends. A frame lasts exactly 64 × D system clocks, where D is the divide ratio.
- R6: Data out changes only while the management clock is low. Each frame has exactly 64 rising edges of the management clock, and input data is sampled during the high phase.
- R7: Divider select values 0..7 give D = 4, 4, 6, 8, 10, 14, 20 and 28. The management clock period is D system clocks, and rising edges are D clocks apart.
- R8: A write to the command or write-data register while a frame runs starts no new frame. It also does not alter or lengthen the running frame.
- R9: While the hold bit is 1 the engine goes idle within two cycles. It aborts any running frame, keeps the clock low and the output enable low, and ignores start writes.
- R10: A command-register write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational on busAddr) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data returned by the PHY |

## Verification
The collision that matters is a host start request landing while a frame is already shifting. The bench provokes it by writing both the write-data register and the command bit in the middle of read and write frames. It judges the result by the frame bits a bench PHY model captures, by the exact busy length, and by the absence of any further clock edges afterwards. The second collision is the hold bit being set mid-frame. That must cut the frame short and block later starts. The bench then runs a normal frame to show the engine recovers.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int DIV_W = 6;

  localparam int REG_CFG  = 0;
  localparam int REG_CMD  = 1;
  localparam int REG_ADR  = 2;
  localparam int REG_WDAT = 3;
  localparam int REG_RDAT = 4;
  localparam int REG_IND  = 5;

  typedef struct packed {
    logic load;      // capture a new frame into the shifter
    logic loadRead;  // frame being loaded is a read
    logic shift;     // advance to next frame bit
    logic sample;    // take one read-data bit from the line
    logic finish;    // read frame complete, publish data
  } mgmtStrb_t;

  function automatic logic [DIV_W-1:0] divFromSel(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1: divFromSel = DIV_W'(4);
      3'd2:       divFromSel = DIV_W'(6);
      3'd3:       divFromSel = DIV_W'(8);
      3'd4:       divFromSel = DIV_W'(10);
      3'd5:       divFromSel = DIV_W'(14);
      3'd6:       divFromSel = DIV_W'(20);
      default:    divFromSel = DIV_W'(28);
    endcase
  endfunction
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hold,
  input  logic [2:0] divSel,
  input  logic       reqRead,
  input  logic       reqWrite,
  output mgmtStrb_t  strb,
  output logic       busy,
  output logic       mdc,
  output logic       mdioOe
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(PRE_BITS + 14);
  localparam logic [BIT_W-1:0] DATA_POS = BIT_W'(PRE_BITS + 16);
  localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divLen, divCnt, halfLen;
  logic [BIT_W-1:0] bitIdx;
  logic             opRead, busyQ;
  logic             lastTick, lastBit, startReq;

  assign halfLen  = divLen >> 1;
  assign lastTick = busyQ && (divCnt == divLen - DIV_W'(1));
  assign lastBit  = (bitIdx == LAST_POS);
  assign startReq = reqRead || reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      opRead <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      divLen <= DIV_W'(4);
    end else if (hold) begin
      busyQ  <= 1'b0;
      opRead <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!busyQ) begin
      if (startReq) begin
        busyQ  <= 1'b1;
        opRead <= reqRead;
        divLen <= divFromSel(divSel);
      end
      divCnt <= '0;
      bitIdx <= '0;
    end else if (lastTick) begin
      divCnt <= '0;
      if (lastBit) busyQ <= 1'b0;
      else         bitIdx <= bitIdx + BIT_W'(1);
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = !busyQ && !hold && startReq;
    strb.loadRead = reqRead;
    strb.shift    = lastTick && !hold;
    strb.sample   = busyQ && !hold && opRead && (divCnt == halfLen) && (bitIdx >= DATA_POS);
    strb.finish   = lastTick && lastBit && opRead && !hold;
  end

  assign busy   = busyQ;
  assign mdc    = busyQ && (divCnt >= halfLen);
  assign mdioOe = busyQ && (!opRead || (bitIdx < TA_POS));
endmodule

// File: rtl/mdio_mgmt_dp.sv
`timescale 1ns/1ps
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  mgmtStrb_t         strb,
  input  logic              busy,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              hold,
  output logic [2:0]        divSel,
  output logic              reqRead,
  output logic              reqWrite,
  output logic [15:0]       rdValue
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_ADR  = ADDR_W'(REG_ADR);
  localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(REG_WDAT);
  localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(REG_RDAT);
  localparam logic [ADDR_W-1:0] A_IND  = ADDR_W'(REG_IND);

  logic                  cfgHold, cmdBit;
  logic [2:0]            cfgSel;
  logic [4:0]            phyNum, regNum;
  logic [15:0]           wrData, rdData, capShift;
  logic [FRAME_BITS-1:0] frameSh;
  logic                  unusedWd;

  assign unusedWd = ^busWdata[31:16];
  assign reqRead  = busWe && (busAddr == A_CMD) && busWdata[0];
  assign reqWrite = busWe && (busAddr == A_WDAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgHold  <= 1'b0;
      cfgSel   <= '0;
      cmdBit   <= 1'b0;
      phyNum   <= '0;
      regNum   <= '0;
      wrData   <= '0;
      rdData   <= '0;
      capShift <= '0;
      frameSh  <= '0;
    end else begin
      if (busWe && busAddr == A_CFG) begin
        cfgHold <= busWdata[15];
        cfgSel  <= busWdata[4:2];
      end
      if (busWe && busAddr == A_CMD) cmdBit <= busWdata[0];
      if (busWe && busAddr == A_ADR) begin
        phyNum <= busWdata[12:8];
        regNum <= busWdata[4:0];
      end
      if (reqWrite) wrData <= busWdata[15:0];

      if (strb.load)
        frameSh <= {{PRE_BITS{1'b1}}, 2'b01,
                    (strb.loadRead ? 2'b10 : 2'b01), phyNum, regNum,
                    (strb.loadRead ? 2'b11 : 2'b10),
                    (strb.loadRead ? 16'hFFFF : busWdata[15:0])};
      else if (strb.shift)
        frameSh <= {frameSh[FRAME_BITS-2:0], 1'b1};

      if (strb.sample) capShift <= {capShift[14:0], mdioIn};
      if (strb.finish) rdData   <= capShift;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_CFG) begin
      busRdata[15]  = cfgHold;
      busRdata[4:2] = cfgSel;
    end else if (busAddr == A_CMD) begin
      busRdata[0] = cmdBit;
    end else if (busAddr == A_ADR) begin
      busRdata[12:8] = phyNum;
      busRdata[4:0]  = regNum;
    end else if (busAddr == A_WDAT) begin
      busRdata[15:0] = wrData;
    end else if (busAddr == A_RDAT) begin
      busRdata[15:0] = rdData;
    end else if (busAddr == A_IND) begin
      busRdata[0] = busy;
    end
  end

  assign mdioOut = frameSh[FRAME_BITS-1];
  assign hold    = cfgHold;
  assign divSel  = cfgSel;
  assign rdValue = rdData;
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mgmtStrb_t   strb;
  logic        hold, busy, reqRead, reqWrite;
  logic [2:0]  divSel;
  logic [15:0] rdValue;

  mdio_mgmt_ctrl #(.PRE_BITS(PRE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .hold(hold), .divSel(divSel),
    .reqRead(reqRead), .reqWrite(reqWrite), .strb(strb),
    .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_mgmt_dp #(.PRE_BITS(PRE_BITS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .strb(strb), .busy(busy),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .hold(hold), .divSel(divSel),
    .reqRead(reqRead), .reqWrite(reqWrite), .rdValue(rdValue)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busy,
  input logic              hold,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [15:0]       rdValue
);
  a_r9_hold_idles: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> (!busy && !mdc));

  a_r6_out_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));

  a_r4_rdata_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdValue));

  a_r4_oe_stays_released: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(mdioOe)) |-> !mdioOe);

  a_r5_write_starts: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(REG_WDAT) && !busy && !hold) |=> busy);
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busy(busy),
  .hold(hold), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdValue(rdValue)
);

// File: tb/test_mdio_mgmt.sv
`timescale 1ns/1ps
module test_mdio_mgmt;
  localparam int FRAME = 64;
  localparam int TA    = 46;
  localparam int DAT   = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_mgmt i_mdio_mgmt (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int riseCnt = 0, fallCnt = 0, riseBase = 0, fallBase = 0;
  logic [63:0] seenOut = '0, seenOe = '0;
  longint tFirst = 0, tLast = 0;
  logic [15:0] respData = '0;

  // bench PHY: record line on rising edges, answer reads on falling edges
  always @(posedge mdc) begin
    int k;
    k = riseCnt - riseBase;
    if (k >= 0 && k < FRAME) begin
      seenOut[FRAME-1-k] = mdioOut;
      seenOe[FRAME-1-k]  = mdioOe;
    end
    if (k == 0) tFirst = $time;
    tLast = $time;
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    int n;
    fallCnt = fallCnt + 1;
    n = fallCnt - fallBase;
    if (n == TA + 1)                mdioIn = 1'b0;
    else if (n >= DAT && n < FRAME) mdioIn = respData[15-(n-DAT)];
    else                            mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a[2:0]; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [31:0] v);
    busAddr = a[2:0];
    #1;
    v = busRdata;
  endtask

  function automatic int tbDiv(input int sel);
    case (sel)
      0, 1: tbDiv = 4;
      2: tbDiv = 6;
      3: tbDiv = 8;
      4: tbDiv = 10;
      5: tbDiv = 14;
      6: tbDiv = 20;
      default: tbDiv = 28;
    endcase
  endfunction

  task automatic doFrame(input bit rd, input int phy, input int rg,
                         input int data, input int sel, input bit poke);
    logic [31:0] v;
    logic [63:0] expF, expOe;
    int c0, dur, d, guard;
    d = tbDiv(sel);
    busWrite(0, sel << 2);
    busWrite(2, ((phy & 31) << 8) | (rg & 31));
    respData = data[15:0];
    riseBase = riseCnt;
    fallBase = fallCnt;
    if (rd) busWrite(1, 1);
    else    busWrite(3, data);
    c0 = cyc;
    busRead(5, v);
    check(v[0] == 1'b1, "R5", "busy after start", v, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      busWrite(3, 32'h0000FFFF);   // R8: start request while busy
      busWrite(1, 1);
    end
    guard = 0;
    busRead(5, v);
    while (v[0] && guard < 5000) begin
      @(negedge clk);
      busRead(5, v);
      guard++;
    end
    dur = cyc - c0;
    check(dur == FRAME * d, "R5", "busy length", dur, FRAME * d);
    check(riseCnt - riseBase == FRAME, "R6", "clock rises per frame", riseCnt - riseBase, FRAME);
    check(tLast - tFirst == longint'(63 * d * 8), "R7", "rise spacing", tLast - tFirst, 63 * d * 8);
    expF = {32'hFFFFFFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy[4:0], rg[4:0], 2'b10, data[15:0]};
    if (rd) begin
      expOe = {{46{1'b1}}, {18{1'b0}}};
      check(seenOut[63:18] == expF[63:18], "R4", "read header bits", seenOut[63:18], expF[63:18]);
      check(seenOe == expOe, "R4", "read enable pattern", seenOe, expOe);
      busRead(4, v);
      check(v == {16'h0, data[15:0]}, "R4", "read data", v, data[15:0]);
      busWrite(1, 0);
    end else begin
      check(seenOut == expF, "R3", "write frame bits", seenOut, expF);
      check(seenOe == '1, "R3", "write enable pattern", seenOe, 64'hFFFFFFFFFFFFFFFF);
    end
    if (poke) begin
      repeat (30) @(negedge clk);
      check(riseCnt - riseBase == FRAME, "R8", "no second frame", riseCnt - riseBase, FRAME);
      busRead(5, v);
      check(v == 0, "R8", "idle after ignored start", v, 0);
      busWrite(1, 0);
    end
  endtask

  initial begin
    logic [31:0] v;
    int r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      busRead(a, v);
      check(v == 0, "R1", "register after reset", v, 0);
    end
    check(mdc == 1'b0, "R1", "mdc after reset", mdc, 0);
    check(mdioOe == 1'b0, "R1", "oe after reset", mdioOe, 0);

    // R2 readback (with hold set, so R9 blocks the starts)
    riseBase = riseCnt;
    busWrite(0, 32'hFFFFFFFF);
    busRead(0, v); check(v == 32'h801C, "R2", "config readback", v, 32'h801C);
    busWrite(2, 32'hFFFFFFFF);
    busRead(2, v); check(v == 32'h1F1F, "R2", "address readback", v, 32'h1F1F);
    busWrite(3, 32'hFFFFFFFF);
    busRead(3, v); check(v == 32'hFFFF, "R2", "write data readback", v, 32'hFFFF);
    busWrite(1, 32'hFFFFFFFF);
    busRead(1, v); check(v == 32'h1, "R2", "command readback", v, 1);
    busRead(6, v); check(v == 0, "R2", "unused offset 6", v, 0);
    busRead(7, v); check(v == 0, "R2", "unused offset 7", v, 0);
    repeat (20) @(negedge clk);
    busRead(5, v); check(v == 0, "R9", "held engine stays idle", v, 0);
    check(riseCnt == riseBase, "R9", "no clock while held", riseCnt - riseBase, 0);
    busWrite(1, 0);
    busWrite(0, 0);

    // R10: command write with bit 0 clear
    riseBase = riseCnt;
    busWrite(1, 32'hFFFFFFFE);
    repeat (20) @(negedge clk);
    busRead(5, v); check(v == 0, "R10", "no start on bit0 clear", v, 0);
    check(riseCnt == riseBase, "R10", "no clock on bit0 clear", riseCnt - riseBase, 0);
    busWrite(1, 0);

    // divider sweep, both directions (R3 R4 R5 R6 R7)
    for (int s = 0; s < 8; s++) begin
      doFrame(1'b0, s * 7 + 3, s * 11 + 5, 16'hA5C3 ^ (s * 16'h1111), s, 1'b0);
      doFrame(1'b1, s * 5 + 1, s * 3 + 2, 16'h3C5A ^ (s * 16'h0F0F), s, 1'b0);
    end

    // field pattern sweep at the fastest divider
    for (int i = 0; i < 16; i++) begin
      doFrame(i[0], i * 2 + 1, 31 - i, (16'h1 << i) ^ (i[1] ? 16'hFFFF : 16'h0), 0, 1'b0);
    end

    // R8: start requests during running frames
    doFrame(1'b0, 9, 18, 16'h1234, 0, 1'b1);
    doFrame(1'b1, 22, 7, 16'hC0DE, 1, 1'b1);

    // R9: hold mid-frame
    busWrite(0, 0);
    busWrite(3, 32'h00FF);
    repeat (40) @(negedge clk);
    busWrite(0, 32'h8000);
    @(negedge clk);
    busRead(5, v); check(v == 0, "R9", "abort clears busy", v, 0);
    check(mdc == 1'b0, "R9", "mdc low while held", mdc, 0);
    check(mdioOe == 1'b0, "R9", "oe low while held", mdioOe, 0);
    r = riseCnt;
    busWrite(3, 32'h0F0F);
    repeat (60) @(negedge clk);
    check(riseCnt == r, "R9", "start ignored while held", riseCnt - r, 0);
    busWrite(0, 0);
    doFrame(1'b1, 3, 7, 16'hBEEF, 2, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule